// File: doc/BRIEF.md
# Transport Packet Capture DMA Controller

This block steers accepted transport packets into a fixed-size region of host memory and reports progress through a single control/status word. Packet words arrive on a valid/ready stream, with a flag on the first word of each packet. Each captured word becomes one 32-bit write request. Its byte address is formed by packing packets back to back from a programmable base address. A packet counter tracks how many whole packets have landed since the fill last restarted.

Software programs a packet threshold. The block raises a sticky DMA-end status when the counter reaches that threshold. If a packet begins while the region already holds its full complement of packets, the packet is consumed and discarded, and a sticky overflow status is set. An almost-full status is also kept, and a live lock input from the frontend is reported. Only the DMA-end and overflow sources can drive the interrupt line, and each has its own mask. Writing one to the acknowledge bit clears the sticky status. An active-low run bit holds the whole capture path in reset, and rewriting the base address restarts the fill from packet zero.

Top module: `ts_capture_dma`

## Requirements
- R1: After reset the control word at offset 0x24 reads 0x0002_7004: run bit 15 low, mask bits 17, 14, 13 and 12 set, threshold field 6:0 equal to 4, count and status zero. The base word at offset 0x20 reads 0, and irq is low.
- R2: Word j of the packet with index k since the last restart is requested at byte address base + 188·k + 4·j, with its data unchanged, and there is one request per word.
- R3: Bits 31:24 of the control word give the number of packets completed since the last restart. The count rises once the last of a packet's 47 words has been accepted.
- R4: The DMA-end status (bit 16) is set when the count becomes equal to a nonzero threshold in bits 6:0, and it stays set. A threshold of 0, or one above the buffer size of 8, never sets it.
- R5: A control write with bit 8 set clears DMA-end (16), overflow (11) and almost-full (10); bit 8 always reads 0, and the count is not touched.
- R6: irq is high exactly when (bit 16 and not bit 17) or (bit 11 and not bit 14). Almost-full and lock never drive it.
- R7: When the count is 8, a new packet is consumed with in_ready high and no write request, overflow is set, and the count stays 8. Almost-full (bit 10) is set when the count reaches 8.
- R8: A write to offset 0x20 stores the base, which reads back. It clears the count and abandons any packet in progress: the rest of that packet's words make no requests. The next packet goes to the new base, and the status bits are kept.
- R9: While bit 15 is 0, the count and the DMA-end, overflow and almost-full bits are held at 0, and stream words are consumed without requests.
- R10: While a captured word's request is not accepted, in_ready is low and the request holds its address and data.
- R11: Bit 9 follows lock_in directly.
- R12: Words without the first-word flag that arrive between packets are discarded without requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| lock_in | input | 1 | Frontend lock indication |
| in_valid | input | 1 | Stream word valid |
| in_first | input | 1 | Marks the first word of a packet |
| in_data | input | 32 | Stream word |
| in_ready | output | 1 | Stream word accepted |
| dma_req_valid | output | 1 | Write request valid |
| dma_req_addr | output | 32 | Write request byte address |
| dma_req_data | output | 32 | Write request data |
| dma_req_ready | input | 1 | Write request accepted |
| irq | output | 1 | Interrupt line |

## Verification
The main capture path is driven with full eight-packet fills at two different bases. The bench then sweeps every threshold from 0 to 9 and checks the DMA-end bit after each packet, which separates an equality trigger from an off-by-one trigger and from thresholds that can never be reached. Further patterns cover an extra packet on a full buffer, a base rewrite in the middle of a packet, stray words between packets, and a stalled write port. These show that dropped words, abandoned words and held words each behave differently. Mask, acknowledge, lock and run-bit writes are checked at the status word and on irq.

// File: rtl/ts_cap_pkg.sv
package ts_cap_pkg;

    localparam int REG_AW  = 6;
    localparam int REG_DW  = 32;
    localparam logic [REG_AW-1:0] OFS_BASE = 6'h20;
    localparam logic [REG_AW-1:0] OFS_CTRL = 6'h24;

    localparam int BIT_DE_MASK   = 17;
    localparam int BIT_DE        = 16;
    localparam int BIT_RUN       = 15;
    localparam int BIT_OVR_MASK  = 14;
    localparam int BIT_AF_MASK   = 13;
    localparam int BIT_LOCK_MASK = 12;
    localparam int BIT_OVR       = 11;
    localparam int BIT_AF        = 10;
    localparam int BIT_LOCK      = 9;
    localparam int BIT_ACK       = 8;
    localparam int THR_W         = 7;
    localparam int CNT_LSB       = 24;
    localparam int CNT_FIELD_W   = 8;

    typedef enum logic [1:0] {
        FR_IDLE = 2'd0,
        FR_CAPT = 2'd1,
        FR_DROP = 2'd2
    } fr_state_e;

    typedef struct packed {
        logic             de_mask;
        logic             run;
        logic             ovr_mask;
        logic             af_mask;
        logic             lock_mask;
        logic [THR_W-1:0] thr;
    } ctrl_t;

    typedef struct packed {
        logic de;
        logic ovr;
        logic af;
    } stat_t;

    function automatic ctrl_t ctrl_from_word(logic [REG_DW-1:0] w);
        ctrl_t c;
        c.de_mask   = w[BIT_DE_MASK];
        c.run       = w[BIT_RUN];
        c.ovr_mask  = w[BIT_OVR_MASK];
        c.af_mask   = w[BIT_AF_MASK];
        c.lock_mask = w[BIT_LOCK_MASK];
        c.thr       = w[THR_W-1:0];
        return c;
    endfunction

    function automatic logic [REG_DW-1:0] pack_ctrl(
        logic [CNT_FIELD_W-1:0] cnt, ctrl_t c, stat_t s, logic lock);
        logic [REG_DW-1:0] w;
        w = '0;
        w[CNT_LSB +: CNT_FIELD_W] = cnt;
        w[BIT_DE_MASK]   = c.de_mask;
        w[BIT_DE]        = s.de;
        w[BIT_RUN]       = c.run;
        w[BIT_OVR_MASK]  = c.ovr_mask;
        w[BIT_AF_MASK]   = c.af_mask;
        w[BIT_LOCK_MASK] = c.lock_mask;
        w[BIT_OVR]       = s.ovr;
        w[BIT_AF]        = s.af;
        w[BIT_LOCK]      = lock;
        w[THR_W-1:0]     = c.thr;
        return w;
    endfunction

endpackage

// File: rtl/ts_cap_regs.sv
module ts_cap_regs
    import ts_cap_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter logic [THR_W-1:0] THR_RESET = 7'd4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_we,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [REG_DW-1:0]   reg_wdata,
    output ctrl_t               ctrl_q,
    output logic [ADDR_W-1:0]   base_q,
    output logic [ADDR_W-1:0]   base_new,
    output logic                base_we,
    output logic                ack
);

    logic ctrl_we;

    assign base_we  = reg_we && (reg_addr == OFS_BASE);
    assign ctrl_we  = reg_we && (reg_addr == OFS_CTRL);
    assign ack      = ctrl_we && reg_wdata[BIT_ACK];
    assign base_new = reg_wdata[ADDR_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q.de_mask   <= 1'b1;
            ctrl_q.run       <= 1'b0;
            ctrl_q.ovr_mask  <= 1'b1;
            ctrl_q.af_mask   <= 1'b1;
            ctrl_q.lock_mask <= 1'b1;
            ctrl_q.thr       <= THR_RESET;
            base_q           <= '0;
        end else begin
            if (ctrl_we) ctrl_q <= ctrl_from_word(reg_wdata);
            if (base_we) base_q <= base_new;
        end
    end

endmodule

// File: rtl/ts_cap_framer.sv
module ts_cap_framer
    import ts_cap_pkg::*;
#(
    parameter int BUF_PKTS   = 8,
    parameter int PKT_WORDS  = 47,
    parameter int WORD_BYTES = 4,
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    localparam int CNT_W     = $clog2(BUF_PKTS + 1),
    localparam int WIDX_W    = (PKT_WORDS > 1) ? $clog2(PKT_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              base_we,
    input  logic [ADDR_W-1:0] base_new,
    input  logic [ADDR_W-1:0] base_q,
    input  logic              in_valid,
    input  logic              in_first,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              dma_valid,
    output logic [ADDR_W-1:0] dma_addr,
    output logic [DATA_W-1:0] dma_data,
    input  logic              dma_ready,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              done_pulse,
    output logic              ovr_pulse
);

    localparam logic [CNT_W-1:0]  CNT_FULL = CNT_W'(BUF_PKTS);
    localparam logic [WIDX_W-1:0] WIDX_END = WIDX_W'(PKT_WORDS - 1);
    localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(WORD_BYTES);

    fr_state_e         st;
    logic [WIDX_W-1:0] widx;
    logic [ADDR_W-1:0] ptr;
    logic              start_ok, start_full, pass, fire, last_word;

    assign start_ok   = run && (st == FR_IDLE) && in_first && (cnt_q < CNT_FULL);
    assign start_full = run && (st == FR_IDLE) && in_first && (cnt_q >= CNT_FULL);
    assign pass       = run && ((st == FR_CAPT) || start_ok);
    assign in_ready   = pass ? dma_ready : 1'b1;
    assign dma_valid  = in_valid && pass;
    assign dma_addr   = ptr;
    assign dma_data   = in_data;
    assign fire       = in_valid && in_ready;
    assign last_word  = (widx == WIDX_END);
    assign done_pulse = fire && pass && last_word && !base_we;
    assign ovr_pulse  = fire && start_full && !base_we;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= FR_IDLE;
            widx  <= '0;
            cnt_q <= '0;
            ptr   <= '0;
        end else if (base_we) begin
            st    <= FR_IDLE;
            widx  <= '0;
            cnt_q <= '0;
            ptr   <= base_new;
        end else if (!run) begin
            st    <= FR_IDLE;
            widx  <= '0;
            cnt_q <= '0;
            ptr   <= base_q;
        end else if (fire) begin
            unique case (st)
                FR_IDLE: begin
                    if (start_ok) begin
                        ptr <= ptr + STEP;
                        if (last_word) begin
                            cnt_q <= cnt_q + 1'b1;
                        end else begin
                            st   <= FR_CAPT;
                            widx <= widx + 1'b1;
                        end
                    end else if (start_full && !last_word) begin
                        st   <= FR_DROP;
                        widx <= widx + 1'b1;
                    end
                end
                FR_CAPT: begin
                    ptr <= ptr + STEP;
                    if (last_word) begin
                        st    <= FR_IDLE;
                        widx  <= '0;
                        cnt_q <= cnt_q + 1'b1;
                    end else begin
                        widx <= widx + 1'b1;
                    end
                end
                FR_DROP: begin
                    if (last_word) begin
                        st   <= FR_IDLE;
                        widx <= '0;
                    end else begin
                        widx <= widx + 1'b1;
                    end
                end
                default: begin
                    st   <= FR_IDLE;
                    widx <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/ts_cap_events.sv
module ts_cap_events
    import ts_cap_pkg::*;
#(
    parameter int BUF_PKTS = 8,
    localparam int CNT_W   = $clog2(BUF_PKTS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctrl_q,
    input  logic             ack,
    input  logic             done_pulse,
    input  logic             ovr_pulse,
    input  logic [CNT_W-1:0] cnt_q,
    output stat_t            stat_q,
    output logic             irq
);

    logic [CNT_FIELD_W-1:0] cnt_after;
    logic                   de_set, af_set;

    assign cnt_after = CNT_FIELD_W'(cnt_q) + 1'b1;
    assign de_set    = done_pulse && (ctrl_q.thr != '0)
                       && (cnt_after == CNT_FIELD_W'(ctrl_q.thr));
    assign af_set    = done_pulse && (cnt_after == CNT_FIELD_W'(BUF_PKTS));

    always_ff @(posedge clk) begin
        if (rst || !ctrl_q.run) begin
            stat_q <= '0;
        end else begin
            stat_q.de  <= de_set    || (stat_q.de  && !ack);
            stat_q.ovr <= ovr_pulse || (stat_q.ovr && !ack);
            stat_q.af  <= af_set    || (stat_q.af  && !ack);
        end
    end

    assign irq = (stat_q.de && !ctrl_q.de_mask) || (stat_q.ovr && !ctrl_q.ovr_mask);

endmodule

// File: rtl/ts_capture_dma.sv
module ts_capture_dma
    import ts_cap_pkg::*;
#(
    parameter int BUF_PKTS   = 8,
    parameter int PKT_BYTES  = 188,
    parameter int WORD_BYTES = 4,
    parameter int ADDR_W     = 32,
    parameter logic [6:0] THR_RESET = 7'd4,
    localparam int DATA_W    = WORD_BYTES * 8,
    localparam int PKT_WORDS = PKT_BYTES / WORD_BYTES,
    localparam int CNT_W     = $clog2(BUF_PKTS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [5:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              lock_in,
    input  logic              in_valid,
    input  logic              in_first,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              dma_req_valid,
    output logic [ADDR_W-1:0] dma_req_addr,
    output logic [DATA_W-1:0] dma_req_data,
    input  logic              dma_req_ready,
    output logic              irq
);

    ctrl_t             ctrl_q;
    stat_t             stat_q;
    logic [ADDR_W-1:0] base_q, base_new;
    logic              base_we, ack, done_pulse, ovr_pulse;
    logic [CNT_W-1:0]  cnt_q;

    ts_cap_regs #(
        .ADDR_W    (ADDR_W),
        .THR_RESET (THR_RESET)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .ctrl_q   (ctrl_q),
        .base_q   (base_q),
        .base_new (base_new),
        .base_we  (base_we),
        .ack      (ack)
    );

    ts_cap_framer #(
        .BUF_PKTS  (BUF_PKTS),
        .PKT_WORDS (PKT_WORDS),
        .WORD_BYTES(WORD_BYTES),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W)
    ) u_framer (
        .clk       (clk),
        .rst       (rst),
        .run       (ctrl_q.run),
        .base_we   (base_we),
        .base_new  (base_new),
        .base_q    (base_q),
        .in_valid  (in_valid),
        .in_first  (in_first),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .dma_valid (dma_req_valid),
        .dma_addr  (dma_req_addr),
        .dma_data  (dma_req_data),
        .dma_ready (dma_req_ready),
        .cnt_q     (cnt_q),
        .done_pulse(done_pulse),
        .ovr_pulse (ovr_pulse)
    );

    ts_cap_events #(
        .BUF_PKTS(BUF_PKTS)
    ) u_events (
        .clk       (clk),
        .rst       (rst),
        .ctrl_q    (ctrl_q),
        .ack       (ack),
        .done_pulse(done_pulse),
        .ovr_pulse (ovr_pulse),
        .cnt_q     (cnt_q),
        .stat_q    (stat_q),
        .irq       (irq)
    );

    always_comb begin
        unique case (reg_addr)
            OFS_BASE: reg_rdata = 32'(base_q);
            OFS_CTRL: reg_rdata = pack_ctrl(CNT_FIELD_W'(cnt_q), ctrl_q, stat_q, lock_in);
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/ts_capture_dma_checker.sv
module ts_capture_dma_checker #(
    parameter int BUF_PKTS   = 8,
    parameter int WORD_BYTES = 4,
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              run,
    input logic              reg_we,
    input logic [5:0]        reg_addr,
    input logic [31:0]       reg_rdata,
    input logic              in_ready,
    input logic              dma_req_valid,
    input logic              dma_req_ready,
    input logic [ADDR_W-1:0] dma_req_addr,
    input logic [DATA_W-1:0] dma_req_data,
    input logic              irq
);

    logic dma_fire;
    assign dma_fire = dma_req_valid && dma_req_ready;

    // R2: consecutive accepted words step by one word
    a_r2_addr_step: assert property (@(posedge clk) disable iff (rst)
        (dma_fire && $past(dma_fire) && !$past(reg_we))
        |-> (dma_req_addr == $past(dma_req_addr) + ADDR_W'(WORD_BYTES)));

    // R6: irq agrees with the status and mask bits read back
    a_r6_irq_sources: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == 6'h24)
        |-> (irq == ((reg_rdata[16] && !reg_rdata[17]) || (reg_rdata[11] && !reg_rdata[14]))));

    // R7: count field never exceeds the buffer size
    a_r7_count_bound: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == 6'h24) |-> (reg_rdata[31:24] <= 8'(BUF_PKTS)));

    // R9: no requests while capture is held in reset
    a_r9_quiet_when_stopped: assert property (@(posedge clk) disable iff (rst)
        !run |-> !dma_req_valid);

    // R10: stream ready follows the write port for captured words
    a_r10_ready_follow: assert property (@(posedge clk) disable iff (rst)
        dma_req_valid |-> (in_ready == dma_req_ready));

    // R10: a stalled request holds its contents
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (dma_req_valid && !dma_req_ready && !reg_we)
        |=> (dma_req_valid && $stable(dma_req_addr) && $stable(dma_req_data)));

endmodule

bind ts_capture_dma ts_capture_dma_checker #(
    .BUF_PKTS  (BUF_PKTS),
    .WORD_BYTES(WORD_BYTES),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W)
) u_checker (
    .clk          (clk),
    .rst          (rst),
    .run          (ctrl_q.run),
    .reg_we       (reg_we),
    .reg_addr     (reg_addr),
    .reg_rdata    (reg_rdata),
    .in_ready     (in_ready),
    .dma_req_valid(dma_req_valid),
    .dma_req_ready(dma_req_ready),
    .dma_req_addr (dma_req_addr),
    .dma_req_data (dma_req_data),
    .irq          (irq)
);

// File: tb/ts_capture_dma_bench.sv
`timescale 1ns/1ps
module ts_capture_dma_bench;

    localparam int PW  = 47;
    localparam int PB  = 188;
    localparam int NB  = 8;
    localparam logic [5:0] A_BASE = 6'h20;
    localparam logic [5:0] A_CTRL = 6'h24;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        lock_in = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_first = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready;
    logic        dma_req_valid;
    logic [31:0] dma_req_addr;
    logic [31:0] dma_req_data;
    logic        dma_req_ready = 1'b1;
    logic        irq;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    ts_capture_dma u_ts_capture_dma (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lock_in(lock_in),
        .in_valid(in_valid), .in_first(in_first), .in_data(in_data),
        .in_ready(in_ready), .dma_req_valid(dma_req_valid),
        .dma_req_addr(dma_req_addr), .dma_req_data(dma_req_data),
        .dma_req_ready(dma_req_ready), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] cw(int thr, bit rn, bit dem, bit om, bit ack);
        logic [31:0] w;
        w = '0;
        w[6:0] = thr[6:0];
        w[8]   = ack;
        w[12]  = 1'b1;
        w[13]  = 1'b1;
        w[14]  = om;
        w[15]  = rn;
        w[17]  = dem;
        return w;
    endfunction

    function automatic logic [31:0] dat(int k, int j);
        return 32'hC0DE_0000 ^ 32'(k * 1000 + j);
    endfunction

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    // sends words j0..j1 of packet k; returns number of mismatching words
    task automatic send(input logic [31:0] b, input int k, input int j0, input int j1,
                        input bit first_ok, input bit expect_cap, output int bad);
        bad = 0;
        for (int j = j0; j <= j1; j++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_first = first_ok && (j == 0);
            in_data  = dat(k, j);
            #1;
            if (expect_cap) begin
                if (!(dma_req_valid && in_ready
                      && dma_req_addr == b + 32'(k * PB + 4 * j)
                      && dma_req_data == dat(k, j))) bad++;
            end else begin
                if (dma_req_valid || !in_ready) bad++;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_first = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        failures++;
        $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] v, a0, a1;
        int bad;
        logic [31:0] b1, b2, b3;
        b1 = 32'h0010_0000;
        b2 = 32'h0020_0040;
        b3 = 32'h0030_1000;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        rd(A_CTRL, v); chk(v == 32'h0002_7004, "R1 ctrl reset", v, 32'h0002_7004);
        chk(irq == 1'b0, "R1 irq reset", 32'(irq), 0);
        rd(A_BASE, v); chk(v == 0, "R1 base reset", v, 0);

        // R9 stream ignored while stopped
        send(0, 0, 0, PW - 1, 1, 0, bad);
        chk(bad == 0, "R9 no requests while stopped", bad, 0);

        // main fill, threshold 4, DE and OVR unmasked
        wr(A_BASE, b1);
        wr(A_CTRL, cw(4, 1, 0, 0, 0));
        for (int k = 0; k < NB; k++) begin
            send(b1, k, 0, PW - 1, 1, 1, bad);
            chk(bad == 0, "R2 packet addresses and data", bad, 0);
            rd(A_CTRL, v);
            chk(v[31:24] == 8'(k + 1), "R3 packet count", 32'(v[31:24]), k + 1);
            chk(v[16] == (k + 1 >= 4), "R4 dma-end at threshold 4", 32'(v[16]), 32'(k + 1 >= 4));
            chk(v[10] == (k + 1 == NB), "R7 almost-full at count 8", 32'(v[10]), 32'(k + 1 == NB));
            chk(irq == v[16], "R6 irq from dma-end", 32'(irq), 32'(v[16]));
        end

        // R7 overflow on full buffer
        send(b1, NB, 0, PW - 1, 1, 0, bad);
        chk(bad == 0, "R7 dropped packet makes no request", bad, 0);
        rd(A_CTRL, v);
        chk(v[11] == 1'b1, "R7 overflow set", 32'(v[11]), 1);
        chk(v[31:24] == 8'd8, "R7 count stays 8", 32'(v[31:24]), 8);
        chk(irq == 1'b1, "R6 irq high", 32'(irq), 1);

        // R5 acknowledge
        wr(A_CTRL, cw(4, 1, 0, 0, 1));
        rd(A_CTRL, v);
        chk(v[16] == 0 && v[11] == 0 && v[10] == 0, "R5 status cleared", v, 32'h0);
        chk(v[8] == 0, "R5 ack reads zero", 32'(v[8]), 0);
        chk(v[31:24] == 8'd8, "R5 count untouched", 32'(v[31:24]), 8);
        chk(irq == 0, "R5 irq low after ack", 32'(irq), 0);

        // R8 restart keeps status
        send(b1, NB, 0, PW - 1, 1, 0, bad);
        wr(A_BASE, b2);
        rd(A_BASE, v); chk(v == b2, "R8 base readback", v, b2);
        rd(A_CTRL, v);
        chk(v[31:24] == 0, "R8 count cleared", 32'(v[31:24]), 0);
        chk(v[11] == 1, "R8 overflow kept", 32'(v[11]), 1);
        send(b2, 0, 0, PW - 1, 1, 1, bad);
        chk(bad == 0, "R8 packet at new base", bad, 0);
        wr(A_CTRL, cw(4, 1, 0, 0, 1));

        // R8 restart in the middle of a packet
        send(b2, 1, 0, 9, 1, 1, bad);
        chk(bad == 0, "R8 partial packet captured", bad, 0);
        wr(A_BASE, b3);
        send(b3, 1, 10, PW - 1, 1, 0, bad);
        chk(bad == 0, "R8 abandoned words dropped", bad, 0);
        send(b3, 0, 0, PW - 1, 1, 1, bad);
        chk(bad == 0, "R8 fresh packet at index 0", bad, 0);
        rd(A_CTRL, v);
        chk(v[31:24] == 1, "R8 count after restart", 32'(v[31:24]), 1);

        // R12 stray words between packets
        send(b3, 1, 3, 7, 0, 0, bad);
        chk(bad == 0, "R12 stray words discarded", bad, 0);
        rd(A_CTRL, v);
        chk(v[31:24] == 1, "R12 count unchanged", 32'(v[31:24]), 1);

        // R10 backpressure
        @(negedge clk);
        dma_req_ready = 1'b0;
        in_valid = 1'b1; in_first = 1'b1; in_data = dat(1, 0);
        #1;
        a0 = dma_req_addr;
        chk(dma_req_valid && !in_ready, "R10 stall holds stream", 32'(in_ready), 0);
        repeat (3) @(negedge clk);
        #1;
        a1 = dma_req_addr;
        chk(dma_req_valid && a1 == a0 && a0 == b3 + PB, "R10 request held", a1, b3 + PB);
        @(negedge clk);
        dma_req_ready = 1'b1;
        send(b3, 1, 1, PW - 1, 1, 1, bad);
        chk(bad == 0, "R10 rest of stalled packet", bad, 0);
        rd(A_CTRL, v);
        chk(v[31:24] == 2, "R10 count after stall", 32'(v[31:24]), 2);

        // R11 lock follows input, no irq
        lock_in = 1'b1;
        rd(A_CTRL, v);
        chk(v[9] == 1 && irq == 0, "R11 lock high", v, 32'h200);
        lock_in = 1'b0;
        rd(A_CTRL, v);
        chk(v[9] == 0, "R11 lock low", 32'(v[9]), 0);

        // R6 mask gating
        wr(A_CTRL, cw(1, 0, 1, 1, 0));
        wr(A_CTRL, cw(1, 1, 1, 1, 0));
        send(b3, 0, 0, PW - 1, 1, 1, bad);
        rd(A_CTRL, v);
        chk(v[16] == 1 && irq == 0, "R6 masked dma-end keeps irq low", 32'(irq), 0);
        wr(A_CTRL, cw(1, 1, 0, 1, 0));
        rd(A_CTRL, v);
        chk(irq == 1, "R6 unmasking raises irq", 32'(irq), 1);

        // R9 soft reset clears
        wr(A_CTRL, cw(1, 0, 0, 0, 0));
        rd(A_CTRL, v);
        chk(v[31:24] == 0 && v[16] == 0 && irq == 0, "R9 stopped clears count and status", v, 32'h0);

        // R4 threshold sweep
        for (int t = 0; t <= 9; t++) begin
            wr(A_CTRL, cw(t, 0, 0, 0, 0));
            wr(A_CTRL, cw(t, 1, 0, 0, 0));
            wr(A_BASE, b1 + 32'(t * 4096));
            for (int k = 1; k <= NB; k++) begin
                send(b1 + 32'(t * 4096), k - 1, 0, PW - 1, 1, 1, bad);
                rd(A_CTRL, v);
                chk(bad == 0 && v[16] == (t != 0 && k >= t), "R4 threshold sweep",
                    32'(v[16]), 32'(t != 0 && k >= t));
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule